// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short record of the most recent resolved branch outcomes, the global history. That history, joined with low bits of the branch address, picks one entry in a table of two-bit saturating counters. The fetch stage presents a PC on the lookup channel. In the same cycle it receives a taken/not-taken guess and the history value that the guess was based on.

When the branch resolves, the back end sends the update channel the PC, the real outcome, the history value saved at lookup time, and a flag saying whether the guess was wrong. The saved history steers training to the counter that produced the guess. The live history takes in the new outcome. After a wrong guess, the history is first restored from the saved value.

Both channels use valid/ready. Neither channel ever applies back-pressure: each ready output is held high, so a beat moves in every cycle that its valid is high. The lookup result is combinational and valid only in the cycle of the request, so the consumer must take it in that cycle. An update beat is committed at the rising edge that ends its cycle.

Top module: `gh_corr_bpred`

## Requirements
- R1: Reset sets every counter to weakly-not-taken (code 01) and clears the history to 0. After reset every lookup returns not-taken with history 0.
- R2: Counter codes are 00 strongly-not-taken, 01 weakly-not-taken, 10 weakly-taken, 11 strongly-taken. The guess is taken exactly when the selected counter's upper bit is 1. The guess depends only on the current lookup PC and the current history, in the same cycle.
- R3: A taken update moves the trained counter one code up. At 11 it stays at 11.
- R4: A not-taken update moves the trained counter one code down. At 00 it stays at 00.
- R5: The entry index is {history[1:0], pc[7:2]} with the defaults. PC bits 1:0 and bits above 7 do not change which entry is used.
- R6: An update trains the entry picked by its saved history input and its PC, not the entry picked by the live history.
- R7: An update whose wrong-guess flag is low shifts the outcome into the history: new history = {old history[0], outcome}.
- R8: An update whose wrong-guess flag is high rebuilds the history from the saved value: new history = {saved[0], outcome}.
- R9: A lookup and an update to the same entry in one cycle: the lookup returns the counter value from before the update. The new value shows from the next cycle on.
- R10: While update valid is low, the counters and the history keep their values, whatever the other update inputs carry.
- R11: Both ready outputs are always 1, and the prediction valid output equals lookup valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup request present |
| lkp_ready | output | 1 | Lookup accepted (always 1) |
| lkp_pc | input | 32 | PC of the branch being fetched |
| pred_valid | output | 1 | Prediction valid this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | 2 | History value used for this prediction |
| upd_valid | input | 1 | Resolved-branch update present |
| upd_ready | output | 1 | Update accepted (always 1) |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | 2 | History saved at prediction time |
| upd_mispred | input | 1 | The earlier prediction was wrong |

## Verification
The lookup result has zero latency: it is due in the same cycle as the lookup PC and the history. Any counter or history change from an update appears on a lookup one cycle after the update beat. The bench drives each vector at the falling edge and samples the prediction and history 2 ns later, before the next rising edge. Each row's expected values therefore show the state left by the earlier rows, not by the current row's update. This separation checks the pre-update read of R9 directly and lets idle rows confirm R10 on the following lookup.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // saturating step toward the observed outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
    else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return nxt;
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_fire,
  input  logic              upd_taken,
  input  logic              upd_mispred,
  input  logic [HIST_W-1:0] upd_snap,
  output logic [HIST_W-1:0] hist_q
);
  logic [HIST_W-2:0] keep_bits;

  // on a wrong guess rebuild from the saved copy, else extend the live value
  assign keep_bits = upd_mispred ? upd_snap[HIST_W-2:0] : hist_q[HIST_W-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (upd_fire) hist_q <= {keep_bits, upd_taken};
  end

  // R7
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !upd_mispred) |=>
      (hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken)}));

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && upd_mispred) |=>
      (hist_q == {$past(upd_snap[HIST_W-2:0]), $past(upd_taken)}));

  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> $stable(hist_q));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_old;

  assign wr_old = ctr_q[wr_idx];
  // read sees the registered value, so a same-cycle write is not visible yet
  assign rd_ctr = ctr_q[rd_idx];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ctr_q[e] <= CTR_WNT;
      else if (wr_en && (wr_idx == IDX_W'(e)))    ctr_q[e] <= ctr_step(ctr_q[e], wr_taken);
    end
  end

  // capture of the last write, used only by the checks below
  logic             chk_wr_q;
  logic             chk_tk_q;
  logic [IDX_W-1:0] chk_idx_q;
  ctr_t             chk_old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_wr_q  <= 1'b0;
      chk_tk_q  <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= CTR_WNT;
    end else begin
      chk_wr_q  <= wr_en;
      chk_tk_q  <= wr_taken;
      chk_idx_q <= wr_idx;
      chk_old_q <= wr_old;
    end
  end

  // R3
  ctr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr_q && chk_tk_q) |->
      ((chk_old_q == CTR_ST) ? (ctr_q[chk_idx_q] == CTR_ST)
                             : (ctr_q[chk_idx_q] == chk_old_q + 2'd1)));

  // R4
  ctr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr_q && !chk_tk_q) |->
      ((chk_old_q == CTR_SNT) ? (ctr_q[chk_idx_q] == CTR_SNT)
                              : (ctr_q[chk_idx_q] == chk_old_q - 2'd1)));
endmodule

// File: rtl/gh_corr_bpred.sv
module gh_corr_bpred
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 2,
  parameter int ALIGN_W  = 2,
  parameter int SET_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  output logic              lkp_ready,
  input  logic [PC_W-1:0]   lkp_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_mispred
);
  localparam int IDX_W  = HIST_W + SET_BITS;
  localparam int PC_TOP = ALIGN_W + SET_BITS - 1;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic              upd_fire;
  ctr_t              rd_ctr;

  assign lkp_ready = 1'b1;
  assign upd_ready = 1'b1;
  assign upd_fire  = upd_valid && upd_ready;

  // the history selects the set, the PC selects the counter within it
  assign rd_idx = {hist_q,   lkp_pc[PC_TOP:ALIGN_W]};
  assign wr_idx = {upd_hist, upd_pc[PC_TOP:ALIGN_W]};

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lkp_pc[PC_W-1:PC_TOP+1], lkp_pc[ALIGN_W-1:0],
                            upd_pc[PC_W-1:PC_TOP+1], upd_pc[ALIGN_W-1:0]};

  bp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_fire    (upd_fire),
    .upd_taken   (upd_taken),
    .upd_mispred (upd_mispred),
    .upd_snap    (upd_hist),
    .hist_q      (hist_q)
  );

  bp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (upd_fire),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken)
  );

  assign pred_valid = lkp_valid;
  assign pred_taken = rd_ctr[1];
  assign pred_hist  = hist_q;

  // R11
  ready_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_ready && upd_ready);
endmodule

// File: tb/gh_corr_bpred_tb.sv
module gh_corr_bpred_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic        lkp_ready;
  logic [31:0] lkp_pc = '0;
  logic        pred_valid;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        upd_valid = 1'b0;
  logic        upd_ready;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [1:0]  upd_hist = '0;
  logic        upd_mispred = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  gh_corr_bpred u_dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_pc(lkp_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist), .upd_mispred(upd_mispred)
  );

  // row: {upd_valid, upd_pc[11:0], upd_taken, upd_hist, upd_mispred,
  //       lkp_pc[11:0], expected pred_taken, expected pred_hist}
  // expectations show the state before this row's update is committed
  localparam int NROW = 21;
  localparam logic [31:0] ROWS [NROW] = '{
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h010, 1'b0, 2'b00}, // 0 R1
    {1'b1, 12'h010, 1'b1, 2'b00, 1'b1, 12'h010, 1'b0, 2'b00}, // 1 R9 pre-update read
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h010, 1'b0, 2'b01}, // 2 R8 R5 history picks set
    {1'b1, 12'h010, 1'b1, 2'b00, 1'b0, 12'h010, 1'b0, 2'b01}, // 3
    {1'b1, 12'h010, 1'b1, 2'b00, 1'b0, 12'h010, 1'b0, 2'b11}, // 4 R7 R3 saturate
    {1'b1, 12'h010, 1'b0, 2'b00, 1'b1, 12'h010, 1'b0, 2'b11}, // 5
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h113, 1'b1, 2'b00}, // 6 R3 R5 R2 one step from top
    {1'b1, 12'h010, 1'b0, 2'b00, 1'b0, 12'h010, 1'b1, 2'b00}, // 7
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h010, 1'b0, 2'b00}, // 8 R2 two contrary flip
    {1'b1, 12'h010, 1'b0, 2'b00, 1'b0, 12'h014, 1'b0, 2'b00}, // 9
    {1'b1, 12'h010, 1'b0, 2'b00, 1'b0, 12'h010, 1'b0, 2'b00}, // 10 R4 floor
    {1'b1, 12'h010, 1'b1, 2'b00, 1'b1, 12'h010, 1'b0, 2'b00}, // 11
    {1'b1, 12'h010, 1'b1, 2'b00, 1'b0, 12'h010, 1'b0, 2'b01}, // 12 R4 floor held
    {1'b0, 12'h010, 1'b0, 2'b00, 1'b1, 12'h010, 1'b0, 2'b11}, // 13 R10 idle beat
    {1'b1, 12'h040, 1'b1, 2'b10, 1'b1, 12'h010, 1'b0, 2'b11}, // 14 R10 history kept
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h040, 1'b0, 2'b01}, // 15 R6 live set untouched
    {1'b1, 12'h080, 1'b1, 2'b01, 1'b0, 12'h040, 1'b0, 2'b01}, // 16
    {1'b1, 12'h080, 1'b0, 2'b11, 1'b1, 12'h040, 1'b0, 2'b11}, // 17
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h040, 1'b1, 2'b10}, // 18 R6 saved set trained
    {1'b1, 12'h200, 1'b0, 2'b00, 1'b1, 12'h010, 1'b0, 2'b10}, // 19
    {1'b0, 12'h000, 1'b0, 2'b00, 1'b0, 12'h010, 1'b1, 2'b00}  // 20 R10 counter kept
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    upd_valid = 1'b0; upd_pc = '0; upd_taken = 1'b0;
    upd_hist = '0; upd_mispred = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lkp_valid = 1'b1;

    // R1 reset state, R11 handshake
    lkp_pc = 32'h0000_0010; #2;
    check("R1 pred after reset", pred_taken, 0);
    check("R1 hist after reset", pred_hist, 0);
    lkp_pc = 32'hFFFF_FFFC; #1;
    check("R1 pred other entry", pred_taken, 0);
    check("R11 ready", {lkp_ready, upd_ready}, 2'b11);
    check("R11 pred_valid high", pred_valid, 1);

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      upd_valid   = ROWS[r][31];
      upd_pc      = {20'd0, ROWS[r][30:19]};
      upd_taken   = ROWS[r][18];
      upd_hist    = ROWS[r][17:16];
      upd_mispred = ROWS[r][15];
      lkp_pc      = {20'd0, ROWS[r][14:3]};
      #2;
      check($sformatf("R2 pred row %0d", r), pred_taken, ROWS[r][2]);
      check($sformatf("R7 hist row %0d", r), pred_hist, ROWS[r][1:0]);
    end

    @(negedge clk);
    idle_inputs();
    lkp_valid = 1'b0; #2;
    check("R11 pred_valid low", pred_valid, 0);
    lkp_valid = 1'b1;

    // R5 high PC bits ignored: entry {00, 4} holds weakly-taken
    lkp_pc = 32'hABCD_E010; #1;
    check("R5 high pc bits", pred_taken, 1);

    // R1 reset in mid-run restores weakly-not-taken and zero history
    rst_n = 1'b0; #1;
    lkp_pc = 32'h0000_0010; #1;
    check("R1 pred after re-reset", pred_taken, 0);
    check("R1 hist after re-reset", pred_hist, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 one taken update from reset gives weakly-taken next cycle
    upd_valid = 1'b1; upd_pc = 32'h0000_0020; upd_taken = 1'b1;
    upd_hist = 2'b00; upd_mispred = 1'b1;
    lkp_pc = 32'h0000_0020; #2;
    check("R9 same entry before commit", pred_taken, 0);
    @(negedge clk);
    idle_inputs();
    lkp_pc = 32'h0000_0020; #2;
    check("R8 hist after restore", pred_hist, 2'b01);
    lkp_pc = 32'h0000_0020; #1;
    check("R6 other set untouched", pred_taken, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule